// File: doc/BRIEF.md
# Saturating Event Tally with Timestamp History

This block counts qualified event pulses for a time-stamped event logger and keeps a short history of when those events happened. Each rising edge on the event input adds one to an 8-bit tally. At the same time the block copies a time vector, supplied from outside, into a small store of timestamp levels. The tally stops at 255 and stays there until the host clears it.

The host reaches the block through a plain register port made of an address, write data and a write strobe. Reads are combinational. Writing zero to the tally register resets the tally and erases every stored timestamp. A separate index register selects which stored level appears on the timestamp output. Writing zero to the index register only points the read at the oldest level and leaves the history intact. The serial bus front end and the time-of-day source sit outside this block.

Top module: `evt_tally_log`

## Requirements
- R1: A rising edge of `evt_in`, taken at the clock edge where it is first sampled high, adds one to the tally. Holding `evt_in` high for many cycles counts once.
- R2: After reset the tally reads 00h, the index reads 0, and every timestamp level reads zero.
- R3: Once the tally reaches 255, further events leave it at 255.
- R4: A write of 00h to address 0Bh (the tally register, all 8 bits are the count) clears the tally and every timestamp level in the same clock edge.
- R5: A write of a non-zero value to address 0Bh leaves the tally unchanged.
- R6: The index register sits at address 0Ch. Its low 2 bits select the level shown on `ts_data`, and it reads back zero-extended. Writing it, including with zero, changes neither the tally nor the stored levels.
- R7: The k-th event after a clear stores `time_vec` at level k-1 while k is 4 or less. Every later event overwrites level 3.
- R8: When a clearing write and an event arrive in the same cycle, the clear wins: the tally ends at 00h and nothing is stored.
- R9: `rdata` returns the tally for address 0Bh, the index for 0Ch, and zero for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Event level; each rising edge is one event |
| time_vec | input | 32 | Current time to capture on an event |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr` |
| ts_data | output | 32 | Timestamp level chosen by the index register |

## Verification
Events are driven as short single pulses, as one long high level, and as a run of more than 255 pulses. Single pulses separate counting on edges from counting on levels. The long run exercises saturation and the overwrite of the last level. The bench writes zero to the tally register and to the index register, and compares the results to show that only the tally write erases history. It also writes a non-zero value to the tally register and issues a clear in the same cycle as an event, which settle which of the two wins and whether the data value matters.

// File: rtl/evt_log_pkg.sv
// Package: shared register map and address width for the event tally block.
// Assumes an 8-bit register address space.
package evt_log_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] TALLY_ADDR = 8'h0B;
    localparam logic [ADDR_W-1:0] INDEX_ADDR = 8'h0C;
endpackage

// File: rtl/evt_edge.sv
// Module: evt_edge
// Turns an event level into a one-cycle pulse on its rising edge.
// Assumes evt_in is already synchronous to clk.
module evt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    // Hold the previous sample of the event level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign pulse = lvl & ~prev_q;
endmodule

// File: rtl/evt_sat_count.sv
// Module: evt_sat_count
// Saturating up-counter with a synchronous clear that has priority.
// Assumes inc is one cycle per event.
module evt_sat_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    // Count events, stopping at the top value; clear overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (clr)                  count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end
endmodule

// File: rtl/evt_ts_store.sv
// Module: evt_ts_store
// Small timestamp history. Captures fill the levels in order and then
// overwrite the last one. Clear zeroes every level and the fill pointer.
// Assumes LEVELS is a power of two and at least 2.
module evt_ts_store #(
    parameter int TW     = 32,
    parameter int LEVELS = 4,
    parameter int IW     = $clog2(LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap,
    input  logic [TW-1:0] tv,
    input  logic [IW-1:0] sel,
    output logic [TW-1:0] rd
);
    localparam int FW = $clog2(LEVELS + 1);
    localparam logic [FW-1:0] FULL = FW'(LEVELS);
    localparam logic [IW-1:0] LAST = IW'(LEVELS - 1);

    logic [FW-1:0] fill_q;
    logic [IW-1:0] wr_lvl;
    logic [TW-1:0] lvl_q [LEVELS];

    // Track how many levels hold data since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fill_q <= '0;
        else if (clr)                  fill_q <= '0;
        else if (cap && fill_q != FULL) fill_q <= fill_q + 1'b1;
    end

    // Pick the next free level, or the last one once the store is full.
    always_comb begin
        wr_lvl = (fill_q < FULL) ? fill_q[IW-1:0] : LAST;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        // Hold one timestamp level; cleared by reset or the clear strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)                          lvl_q[g] <= '0;
            else if (clr)                        lvl_q[g] <= '0;
            else if (cap && wr_lvl == IW'(g))    lvl_q[g] <= tv;
        end
    end

    assign rd = lvl_q[sel];
endmodule

// File: rtl/evt_tally_log.sv
// Module: evt_tally_log
// Event tally with timestamp history behind a simple register port.
// A zero write to the tally register clears the tally and the history.
// The index register selects the level on ts_data.
// Assumes inputs are synchronous to clk and that reads are combinational.
module evt_tally_log
    import evt_log_pkg::*;
#(
    parameter int CW     = 8,
    parameter int TW     = 32,
    parameter int LEVELS = 4,
    parameter int IW     = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic [TW-1:0]     time_vec,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    output logic [TW-1:0]     ts_data
);
    logic          evt_pulse;
    logic          clr_req;
    logic          idx_wr;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;

    // Decode the two host writes.
    always_comb begin
        clr_req = wr_en && (addr == TALLY_ADDR) && (wdata == '0);
        idx_wr  = wr_en && (addr == INDEX_ADDR);
    end

    evt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (evt_in),
        .pulse (evt_pulse)
    );

    evt_sat_count #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_req),
        .inc   (evt_pulse),
        .count (cnt_q)
    );

    evt_ts_store #(.TW(TW), .LEVELS(LEVELS), .IW(IW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_req),
        .cap   (evt_pulse & ~clr_req),
        .tv    (time_vec),
        .sel   (idx_q),
        .rd    (ts_data)
    );

    // Hold the read index; only its low bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata[IW-1:0];
    end

    // Return the addressed register, zero elsewhere.
    always_comb begin
        if (addr == TALLY_ADDR)      rdata = cnt_q;
        else if (addr == INDEX_ADDR) rdata = {{(CW-IW){1'b0}}, idx_q};
        else                         rdata = '0;
    end
endmodule

// File: rtl/evt_tally_log_chk.sv
// Module: evt_tally_log_chk
// Checker for evt_tally_log, attached with bind below.
// Assumes the same register map as the design.
module evt_tally_log_chk
    import evt_log_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = 32,
    parameter int IW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CW-1:0]     wdata,
    input logic [CW-1:0]     count,
    input logic              pulse,
    input logic [TW-1:0]     ts_data,
    input logic [IW-1:0]     idx
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};
    logic clr_w;
    assign clr_w = wr_en && addr == TALLY_ADDR && wdata == '0;

    // R1
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !clr_w && count != TOP) |=> count == CW'($past(count) + 1'b1));
    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr_w) |=> count == TOP);
    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (count == '0 && ts_data == '0));
    // R5
    nz_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == TALLY_ADDR && wdata != '0 && !pulse) |=> $stable(count));
    // R6
    idx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == INDEX_ADDR && !pulse) |=> ($stable(count) && idx == $past(wdata[IW-1:0])));
    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && pulse) |=> count == '0);
endmodule

bind evt_tally_log evt_tally_log_chk #(.CW(CW), .TW(TW), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .count   (cnt_q),
    .pulse   (evt_pulse),
    .ts_data (ts_data),
    .idx     (idx_q)
);

// File: tb/sim_evt_tally_log.sv
module sim_evt_tally_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic [31:0] time_vec = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [31:0] ts_data;

    typedef struct {
        bit          is_ts;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state built from the requirements.
    int          m_cnt;
    logic [31:0] m_lvl [4];
    int          m_fill;

    always #5 clk = ~clk;

    evt_tally_log u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .time_vec(time_vec),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .ts_data(ts_data)
    );

    // Monitor: pop and compare expected items away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_ts ? ts_data : {24'h0, rdata};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic m_clear();
        m_cnt = 0;
        m_fill = 0;
        for (int i = 0; i < 4; i++) m_lvl[i] = '0;
    endtask

    task automatic m_event(logic [31:0] tv);
        if (m_cnt < 255) m_cnt++;
        m_lvl[(m_fill < 4) ? m_fill : 3] = tv;
        if (m_fill < 4) m_fill++;
    endtask

    task automatic pulse_evt(logic [31:0] tv);
        time_vec = tv;
        evt_in = 1'b1;
        tick();
        evt_in = 1'b0;
        m_event(tv);
        tick();
    endtask

    task automatic reg_write(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk_reg(logic [7:0] a, logic [7:0] e, string req);
        item_t it;
        addr = a;
        it.is_ts = 1'b0; it.exp = {24'h0, e}; it.req = req;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic chk_lvl(int lvl, string req);
        item_t it;
        reg_write(8'h0C, 8'(lvl));
        it.is_ts = 1'b1; it.exp = m_lvl[lvl]; it.req = req;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic chk_all_lvls(string req);
        for (int i = 0; i < 4; i++) chk_lvl(i, req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver.
    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tick();
        // R2 reset state
        chk_reg(8'h0B, 8'h00, "R2 tally");
        chk_reg(8'h0C, 8'h00, "R2 index");
        chk_all_lvls("R2 level");
        // R1 single pulses
        for (int i = 0; i < 3; i++) pulse_evt(32'h100 + i);
        chk_reg(8'h0B, 8'(m_cnt), "R1 tally after pulses");
        chk_all_lvls("R7 fill order");
        // R1 held level counts once
        time_vec = 32'hABCD;
        evt_in = 1'b1;
        repeat (5) tick();
        evt_in = 1'b0;
        m_event(32'hABCD);
        tick();
        chk_reg(8'h0B, 8'(m_cnt), "R1 held level");
        // R7 overwrite of last level
        pulse_evt(32'h2000);
        pulse_evt(32'h3000);
        chk_all_lvls("R7 overwrite");
        // R6 zero index write keeps data, readback
        reg_write(8'h0C, 8'h00);
        chk_reg(8'h0C, 8'h00, "R6 index readback");
        chk_reg(8'h0B, 8'(m_cnt), "R6 tally kept");
        chk_lvl(0, "R6 level kept");
        reg_write(8'h0C, 8'h07);
        chk_reg(8'h0C, 8'h03, "R6 index low bits");
        // R5 nonzero tally write ignored
        reg_write(8'h0B, 8'h55);
        chk_reg(8'h0B, 8'(m_cnt), "R5 nonzero write");
        // R9 unmapped address
        chk_reg(8'h20, 8'h00, "R9 unmapped");
        // R4 clear
        reg_write(8'h0B, 8'h00);
        m_clear();
        chk_reg(8'h0B, 8'h00, "R4 tally cleared");
        chk_all_lvls("R4 levels cleared");
        // R8 clear and event together
        time_vec = 32'h7777;
        evt_in = 1'b1;
        wr_en = 1'b1; addr = 8'h0B; wdata = 8'h00;
        tick();
        wr_en = 1'b0; evt_in = 1'b0;
        tick();
        chk_reg(8'h0B, 8'h00, "R8 tally");
        chk_lvl(0, "R8 level");
        // R3 saturation
        for (int i = 0; i < 260; i++) pulse_evt(32'h5000 + i);
        chk_reg(8'h0B, 8'hFF, "R3 saturated");
        chk_lvl(3, "R7 last level after many");
        chk_lvl(0, "R7 first level after many");
        reg_write(8'h0B, 8'h00);
        m_clear();
        chk_reg(8'h0B, 8'h00, "R4 clear from saturation");
        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule